// File: doc/BRIEF.md
# Unaligned Word Bus Cycle Splitter

This block sits between an execution unit that issues byte and word memory or I/O accesses at any address and an external 16-bit bus that only accepts aligned cycles. A word access at an even address runs as a single word cycle. A word access at an odd address is broken into two sequential byte cycles. The first cycle goes to the odd address on the upper lane. The second goes to the following even address on the lower lane. The two bytes are reassembled for reads, or taken from the request and steered onto the correct lanes for writes. To the requester, the access still looks like one unaligned word.

The requester pulses `req_valid` for one cycle while the block is idle, together with the access attributes. It then waits for the single-cycle `req_done` pulse, after which `req_rdata` holds the read result. Every external cycle holds its address, strobes and data until `bus_ready` is sampled high at a rising clock edge.

Top module: `ubus_splitter`

## Requirements
- R1: After synchronous reset, `bus_rd`, `bus_wr`, `bus_word` and `req_done` are low.
- R2: A word access at an even address runs exactly one external cycle, with `bus_word` high and `bus_addr` equal to the request address.
- R3: A word access at an odd address runs exactly two external byte cycles (`bus_word` low): first at the request address, then at the request address plus one.
- R4: For a split read, `req_rdata[7:0]` is the upper lane `bus_rdata[15:8]` of the first cycle, and `req_rdata[15:8]` is the lower lane `bus_rdata[7:0]` of the second cycle.
- R5: For a split write, the first cycle drives `req_wdata[7:0]` on `bus_wdata[15:8]` with the lower lane zero. The second cycle drives `req_wdata[15:8]` on `bus_wdata[7:0]` with the upper lane zero.
- R6: A byte read returns the lane selected by address bit 0 (1 selects bits 15:8) in `req_rdata[7:0]`, with `req_rdata[15:8]` zero.
- R7: A byte write places `req_wdata[7:0]` on the lane selected by address bit 0, with the other lane zero.
- R8: While a strobe is high and `bus_ready` is low, `bus_addr`, `bus_rd`, `bus_wr`, `bus_word` and `bus_wdata` hold their values.
- R9: `bus_io` equals the request's io attribute during every cycle of an access, including both halves of a split access.
- R10: `req_done` is a one-cycle pulse in the cycle after the final external cycle completes, and never after a first half.
- R11: `req_valid` asserted while an access is in progress is ignored and starts no external cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | I/O space attribute |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read result, valid with and after `req_done` |
| bus_addr | output | ADDR_W | External cycle address |
| bus_rd | output | 1 | External read strobe |
| bus_wr | output | 1 | External write strobe |
| bus_io | output | 1 | External I/O attribute |
| bus_word | output | 1 | External word-size cycle |
| bus_wdata | output | 16 | External write data, lane-steered |
| bus_rdata | input | 16 | External read data, both lanes |
| bus_ready | input | 1 | Cycle completes at an edge where this is high |

## Verification
A wrong phase register shows up at the ports within one external cycle. It appears as a missing or extra byte cycle, a second address that is not the first plus one, or a word strobe on an odd address. A lost or misplaced captured byte corrupts only one half of `req_rdata`, and that is visible at the `req_done` pulse. A lane-steering error is visible on `bus_wdata` during the faulty half, and again in memory when the written bytes are read back. Stall handling errors show up in the first wait-state cycle as a change of address or strobe.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

    localparam int LANE_W = 8;
    localparam int BUS_W  = 2 * LANE_W;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_t;

    typedef struct packed {
        logic write;
        logic io;
        logic word;
        logic split;
    } attr_t;

    function automatic logic [BUS_W-1:0] lane_place(input logic [LANE_W-1:0] b, input logic hi);
        return hi ? {b, {LANE_W{1'b0}}} : {{LANE_W{1'b0}}, b};
    endfunction

    function automatic logic [LANE_W-1:0] lane_pick(input logic [BUS_W-1:0] d, input logic hi);
        return hi ? d[BUS_W-1:LANE_W] : d[LANE_W-1:0];
    endfunction

endpackage

// File: rtl/bsplit_fsm.sv
module bsplit_fsm
    import bsplit_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   bus_ready,
    input  logic   split,
    output phase_t phase,
    output logic   accept,
    output logic   step,
    output logic   final_step
);

    phase_t ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_IDLE;
        end else begin
            case (ph)
                PH_IDLE:   if (req_valid) ph <= PH_FIRST;
                PH_FIRST:  if (bus_ready) ph <= split ? PH_SECOND : PH_IDLE;
                PH_SECOND: if (bus_ready) ph <= PH_IDLE;
                default:   ph <= PH_IDLE;
            endcase
        end
    end

    assign phase      = ph;
    assign accept     = (ph == PH_IDLE) && req_valid;
    assign step       = (ph != PH_IDLE) && bus_ready;
    assign final_step = step && ((ph == PH_SECOND) || !split);

    // R3: the second half is only ever entered from the first half
    a_r3_second_from_first: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_SECOND) && ($past(ph) != PH_SECOND) |-> $past(ph) == PH_FIRST);

endmodule

// File: rtl/bsplit_plan.sv
module bsplit_plan
    import bsplit_pkg::*;
#(
    parameter int ADDR_W = 20
)(
    input  phase_t            phase,
    input  logic [ADDR_W-1:0] base_addr,
    input  attr_t             attr,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic              cyc_word,
    output logic              hi_lane,
    output logic              active
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_comb begin
        active   = (phase != PH_IDLE);
        cyc_addr = (phase == PH_SECOND) ? base_addr + ONE : base_addr;
        cyc_word = attr.word && !attr.split;
        hi_lane  = cyc_addr[0];
    end

endmodule

// File: rtl/bsplit_lanes.sv
module bsplit_lanes
    import bsplit_pkg::*;
(
    input  phase_t            phase,
    input  attr_t             attr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [BUS_W-1:0]  bus_rdata,
    input  logic              hi_lane,
    input  logic [LANE_W-1:0] low_keep,
    output logic [BUS_W-1:0]  wr_lanes,
    output logic [BUS_W-1:0]  rd_word,
    output logic [LANE_W-1:0] picked
);

    logic [LANE_W-1:0] wr_byte;

    always_comb begin
        picked  = lane_pick(bus_rdata, hi_lane);
        wr_byte = (phase == PH_SECOND) ? wdata[BUS_W-1:LANE_W] : wdata[LANE_W-1:0];

        if (attr.word && !attr.split)
            wr_lanes = wdata;
        else
            wr_lanes = lane_place(wr_byte, hi_lane);

        if (attr.word && !attr.split)
            rd_word = bus_rdata;
        else if (attr.split)
            rd_word = {picked, low_keep};
        else
            rd_word = {{LANE_W{1'b0}}, picked};
    end

endmodule

// File: rtl/ubus_splitter.sv
module ubus_splitter
    import bsplit_pkg::*;
#(
    parameter int ADDR_W = 20
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    output logic              req_done,
    output logic [15:0]       req_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_io,
    output logic              bus_word,
    output logic [15:0]       bus_wdata,
    input  logic [15:0]       bus_rdata,
    input  logic              bus_ready
);

    phase_t            phase;
    logic              accept, step, final_step;
    attr_t             attr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BUS_W-1:0]  wdata_q;
    logic [LANE_W-1:0] low_keep;
    logic [ADDR_W-1:0] cyc_addr;
    logic              cyc_word, hi_lane, active;
    logic [BUS_W-1:0]  wr_lanes, rd_word;
    logic [LANE_W-1:0] picked;
    logic              done_q;
    logic [BUS_W-1:0]  rdata_q;

    bsplit_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .bus_ready  (bus_ready),
        .split      (attr_q.split),
        .phase      (phase),
        .accept     (accept),
        .step       (step),
        .final_step (final_step)
    );

    bsplit_plan #(.ADDR_W(ADDR_W)) u_plan (
        .phase     (phase),
        .base_addr (addr_q),
        .attr      (attr_q),
        .cyc_addr  (cyc_addr),
        .cyc_word  (cyc_word),
        .hi_lane   (hi_lane),
        .active    (active)
    );

    bsplit_lanes u_lanes (
        .phase     (phase),
        .attr      (attr_q),
        .wdata     (wdata_q),
        .bus_rdata (bus_rdata),
        .hi_lane   (hi_lane),
        .low_keep  (low_keep),
        .wr_lanes  (wr_lanes),
        .rd_word   (rd_word),
        .picked    (picked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            attr_q   <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            low_keep <= '0;
            done_q   <= 1'b0;
            rdata_q  <= '0;
        end else begin
            done_q <= final_step;
            if (accept) begin
                attr_q  <= '{write: req_write, io: req_io, word: req_word,
                             split: req_word && req_addr[0]};
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (step && !final_step)
                low_keep <= picked;
            if (final_step && !attr_q.write)
                rdata_q <= rd_word;
        end
    end

    assign req_done  = done_q;
    assign req_rdata = rdata_q;
    assign bus_addr  = active ? cyc_addr : '0;
    assign bus_rd    = active && !attr_q.write;
    assign bus_wr    = active && attr_q.write;
    assign bus_io    = active && attr_q.io;
    assign bus_word  = active && cyc_word;
    assign bus_wdata = (active && attr_q.write) ? wr_lanes : '0;

    a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) && !bus_ready |=>
            $stable(bus_addr) && $stable(bus_rd) && $stable(bus_wr) &&
            $stable(bus_word) && $stable(bus_wdata));

    a_r2_word_aligned: assert property (@(posedge clk) disable iff (rst)
        bus_word |-> !bus_addr[0]);

    a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    a_r9_io_held: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) && $past(bus_rd || bus_wr) |-> bus_io == $past(bus_io));

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        req_done |=> !req_done);

    a_r10_done_after_ready: assert property (@(posedge clk) disable iff (rst)
        req_done |-> $past((bus_rd || bus_wr) && bus_ready));

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !bus_rd && !bus_wr && !req_done);

endmodule

// File: tb/ubus_splitter_test.sv
module ubus_splitter_test;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, req_word = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic          req_done;
    logic [15:0]   req_rdata;
    logic [AW-1:0] bus_addr;
    logic          bus_rd, bus_wr, bus_io, bus_word;
    logic [15:0]   bus_wdata;
    logic [15:0]   bus_rdata = '0;
    logic          bus_ready = 1'b0;

    int tests = 0, fails = 0;
    int wait_n = 0, wcnt = 0;
    logic [7:0] mem [256];
    int nlog = 0, hold_err = 0;
    logic [AW-1:0] log_addr [8];
    logic          log_word [8];
    logic          log_io   [8];
    logic [15:0]   log_wd   [8];
    logic          pend = 1'b0;
    logic [AW-1:0] pend_addr;
    logic [15:0]   pend_wd;
    logic          pend_rd, pend_wr, pend_word;

    always #10 clk = ~clk;

    ubus_splitter #(.ADDR_W(AW)) uut (.*);

    always @(negedge clk) begin
        logic strobe;
        strobe = bus_rd || bus_wr;
        if (strobe && pend &&
            (bus_addr != pend_addr || bus_rd != pend_rd || bus_wr != pend_wr ||
             bus_word != pend_word || bus_wdata != pend_wd))
            hold_err = hold_err + 1;
        bus_rdata = {mem[{bus_addr[7:1], 1'b1}], mem[{bus_addr[7:1], 1'b0}]};
        bus_ready = strobe && (wcnt == wait_n);
        if (bus_ready) begin
            if (nlog < 8) begin
                log_addr[nlog] = bus_addr; log_word[nlog] = bus_word;
                log_io[nlog] = bus_io;     log_wd[nlog] = bus_wdata;
            end
            nlog = nlog + 1;
            if (bus_wr) begin
                if (bus_word || bus_addr[0]) mem[{bus_addr[7:1], 1'b1}] = bus_wdata[15:8];
                if (bus_word || !bus_addr[0]) mem[{bus_addr[7:1], 1'b0}] = bus_wdata[7:0];
            end
            wcnt = 0;
            pend = 1'b0;
        end else begin
            wcnt = strobe ? wcnt + 1 : 0;
            pend = strobe;
            pend_addr = bus_addr; pend_rd = bus_rd; pend_wr = bus_wr;
            pend_word = bus_word; pend_wd = bus_wdata;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one access; checks done timing (R10) and extra requests ignored (R11)
    task automatic access(input logic wr, input logic io, input logic wd,
                          input logic [AW-1:0] a, input logic [15:0] d,
                          input int exp_cycles, output logic [15:0] rd);
        int guard = 0;
        nlog = 0; hold_err = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_io = io; req_word = wd;
        req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a + 8;       // R11: poke while busy
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_done && guard < 100) begin @(negedge clk); guard++; end
        check("R10 done seen", 32'(req_done), 32'd1);
        check("R10 done after final cycle", 32'(nlog), 32'(exp_cycles));
        rd = req_rdata;
        @(negedge clk);
        check("R10 done one cycle", 32'(req_done), 32'd0);
        repeat (4) @(negedge clk);
        check("R11 busy request ignored", 32'(nlog), 32'(exp_cycles));
        check("R8 hold during wait", 32'(hold_err), 32'd0);
    endtask

    task automatic t_reset;
        check("R1 rd low", 32'(bus_rd), 32'd0);
        check("R1 wr low", 32'(bus_wr), 32'd0);
        check("R1 word low", 32'(bus_word), 32'd0);
        check("R1 done low", 32'(req_done), 32'd0);
    endtask

    task automatic t_even_word;
        logic [15:0] r;
        wait_n = 1;
        access(1'b0, 1'b0, 1'b1, 20'h00010, 16'h0, 1, r);
        check("R2 word flag", 32'(log_word[0]), 32'd1);
        check("R2 address", 32'(log_addr[0]), 32'h10);
        check("R2 data", 32'(r), {16'h0, mem[8'h11], mem[8'h10]});
    endtask

    task automatic t_odd_word_read;
        logic [15:0] r;
        wait_n = 2;
        access(1'b0, 1'b0, 1'b1, 20'h00021, 16'h0, 2, r);
        check("R3 first addr", 32'(log_addr[0]), 32'h21);
        check("R3 second addr", 32'(log_addr[1]), 32'h22);
        check("R3 byte cycles", 32'({log_word[0], log_word[1]}), 32'd0);
        check("R4 assembled", 32'(r), {16'h0, mem[8'h22], mem[8'h21]});
        check("R9 io low both", 32'({log_io[0], log_io[1]}), 32'd0);
    endtask

    task automatic t_odd_word_write;
        logic [15:0] r;
        wait_n = 0;
        access(1'b1, 1'b1, 1'b1, 20'h00033, 16'hBEEF, 2, r);
        check("R5 first lanes", 32'(log_wd[0]), 32'hEF00);
        check("R5 second lanes", 32'(log_wd[1]), 32'h00BE);
        check("R9 io high both", 32'({log_io[0], log_io[1]}), 32'd3);
        check("R5 mem 0x33", 32'(mem[8'h33]), 32'hEF);
        check("R5 mem 0x34", 32'(mem[8'h34]), 32'hBE);
        wait_n = 1;
        access(1'b0, 1'b0, 1'b1, 20'h00033, 16'h0, 2, r);
        check("R4 readback", 32'(r), 32'hBEEF);
    endtask

    task automatic t_byte_read;
        logic [15:0] r;
        wait_n = 0;
        access(1'b0, 1'b0, 1'b0, 20'h00045, 16'h0, 1, r);
        check("R6 odd byte", 32'(r), {24'h0, mem[8'h45]});
        access(1'b0, 1'b0, 1'b0, 20'h00044, 16'h0, 1, r);
        check("R6 even byte", 32'(r), {24'h0, mem[8'h44]});
        check("R6 byte cycle", 32'(log_word[0]), 32'd0);
    endtask

    task automatic t_byte_write;
        logic [15:0] r;
        logic [7:0]  keep;
        keep = mem[8'h51];
        wait_n = 1;
        access(1'b1, 1'b0, 1'b0, 20'h00050, 16'h775A, 1, r);
        check("R7 even lanes", 32'(log_wd[0]), 32'h005A);
        check("R7 neighbour kept", 32'(mem[8'h51]), 32'(keep));
        access(1'b1, 1'b1, 1'b0, 20'h00061, 16'h33C3, 1, r);
        check("R7 odd lanes", 32'(log_wd[0]), 32'hC300);
        check("R9 io byte", 32'(log_io[0]), 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_even_word();
        t_odd_word_read();
        t_odd_word_write();
        t_byte_read();
        t_byte_write();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        tests = tests + 1;
        fails = fails + 1;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule